// File: doc/BRIEF.md
# BCD Calendar Clock with Exact-Match Alarm

This block keeps wall-clock time and a calendar date as packed BCD bytes (seconds, minutes, hours, day of month, month, two-digit year). A 32768 Hz enable strobe drives a prescaler. Each time the prescaler wraps, the calendar advances one second and carries through to minutes, hours, day, month and year. Day rollover follows the length of each month. A year whose value is a multiple of four is a leap year.

Software reaches the block over a small register bus. A write is a single-cycle strobe with an 8-bit address and 32-bit data, of which only the low byte matters except for the unlock keys. Reads are combinational. Writes are refused until a two-key unlock sequence has been performed.

Software reads a busy flag that warns of the coming one-second step, so that it can read or write the counters without being split by a carry. A single alarm compares all six fields with no masking. A periodic timer interrupt and an alarm interrupt are each gated by an enable bit.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00. Seconds and minutes count 00..59 and carry on wrapping. Hours count 00..23 and wrap to 00 with a carry into the day.
- R2: The day wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February.
- R3: February wraps after 29 when the year byte is a multiple of four (00, 04, ..., 96), and after 28 otherwise.
- R4: Month 12 wraps to 01 with a carry into the year. Year 99 wraps to 00.
- R5: With control bit 0 set, the calendar advances one second after every TICKS_PER_SEC cycles with tick_en high. With control bit 0 clear, the counters hold regardless of tick_en.
- R6: Status bit 0 (busy) is 1 exactly while running and the prescaler is in its last tick period before the step.
- R7: Status bit 2 is set by every one-second step. Status bit 6 is the alarm flag. Each is cleared by writing 1 to it at 0x44. Status bit 1 reads the run bit.
- R8: The alarm flag sets after a step only when all six alarm bytes equal the new time. A single differing field prevents it.
- R9: timer_irq is status bit 2 AND enable bit 2 at 0x48. alarm_irq is status bit 6 AND enable bit 3 at 0x48.
- R10: Writes take effect only after 0x83E70B13 is written to 0x6C and then 0x95A4F1E0 to 0x70.
- R11: Writes made while locked are ignored. A wrong key or key order does not unlock. Writing 0 to either key register locks again.
- R12: The time fields are at 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 (seconds first). The alarm fields use the same order at 0x20..0x34. Control is at 0x40, where only bit 0 is kept and bit 3 reads 0 so that the clock stays in 24-hour mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle 32768 Hz enable strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data (keys use all 32 bits) |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| timer_irq | output | 1 | One-second interrupt |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The bench drives the calendar across the carries that catch most mistakes:
- 23:59:59 on 28 and 29 February in leap and common years;
- the end of a 30-day month;
- the wrap from 31 December 99.

A wrong month-length table shows up as day 29 or 31 where 01 is expected. A year carry taken at the wrong place leaves the year at 9A or stuck.

The busy flag is sampled one tick before the step and just after it, so a busy flag shifted by one period fails. The alarm is tried with only the year differing, which a design that compares a subset of fields would wrongly flag.

For the lock, the bench writes while locked, writes the keys in reverse order and relocks. A design that unlocks on any key write, or ignores the order, lets the time change.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int NFIELD = 6;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YR   = 5;

  typedef logic [NFIELD-1:0][7:0] cal_t;

  // year, month, day, hour, minute, second
  localparam cal_t CAL_RESET = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of four in BCD: even tens with units 0/4/8, odd tens with 2/6
  function automatic logic is_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yr);
    case (mo)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic cal_t advance(input cal_t c);
    cal_t n;
    n = c;
    if (c[F_SEC] != 8'h59) begin
      n[F_SEC] = bcd_inc(c[F_SEC]);
    end else begin
      n[F_SEC] = 8'h00;
      if (c[F_MIN] != 8'h59) begin
        n[F_MIN] = bcd_inc(c[F_MIN]);
      end else begin
        n[F_MIN] = 8'h00;
        if (c[F_HR] != 8'h23) begin
          n[F_HR] = bcd_inc(c[F_HR]);
        end else begin
          n[F_HR] = 8'h00;
          if (c[F_DAY] != month_len(c[F_MON], c[F_YR])) begin
            n[F_DAY] = bcd_inc(c[F_DAY]);
          end else begin
            n[F_DAY] = 8'h01;
            if (c[F_MON] != 8'h12) begin
              n[F_MON] = bcd_inc(c[F_MON]);
            end else begin
              n[F_MON] = 8'h01;
              n[F_YR]  = (c[F_YR] == 8'h99) ? 8'h00 : bcd_inc(c[F_YR]);
            end
          end
        end
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_en,
  output logic busy,
  output logic step
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign busy    = run && at_last;

  always_comb begin
    cnt_d = cnt_q;
    step  = 1'b0;
    if (run && tick_en) begin
      if (at_last) begin
        cnt_d = '0;
        step  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_STOPPED_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/rtc_unlock.sv
module rtc_unlock #(
  parameter logic [7:0]  KEY_A_ADDR = 8'h6C,
  parameter logic [7:0]  KEY_B_ADDR = 8'h70,
  parameter logic [31:0] KEY_A      = 32'h83E70B13,
  parameter logic [31:0] KEY_B      = 32'h95A4F1E0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        unlocked
);
  typedef enum logic [1:0] {LK_CLOSED, LK_HALF, LK_OPEN} lk_state_t;
  lk_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (bus_wr && bus_addr == KEY_A_ADDR) begin
      if (bus_wdata == KEY_A) st_d = (st_q == LK_OPEN) ? LK_OPEN : LK_HALF;
      else                    st_d = LK_CLOSED;
    end else if (bus_wr && bus_addr == KEY_B_ADDR) begin
      if (bus_wdata == KEY_B && st_q != LK_CLOSED) st_d = LK_OPEN;
      else                                         st_d = LK_CLOSED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_CLOSED;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == LK_OPEN);

  AST_OPEN_NEEDS_SECOND_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_wr && bus_addr == KEY_B_ADDR && bus_wdata == KEY_B)); // R10
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [NFIELD-1:0] ld_en,
  input  logic [7:0]        ld_data,
  output cal_t              cal_q
);
  cal_t adv, cal_d;

  assign adv = advance(cal_q);

  always_comb begin
    for (int i = 0; i < NFIELD; i++) begin
      if (ld_en[i])  cal_d[i] = ld_data;
      else if (step) cal_d[i] = adv[i];
      else           cal_d[i] = cal_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_q <= CAL_RESET;
    else        cal_q <= cal_d;
  end

  AST_DATE_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) && $past(ld_en) == '0 && $past(cal_q[F_DAY]) != 8'h00
     && $past(cal_q[F_MON]) != 8'h00)
    |-> (cal_q[F_DAY] != 8'h00 && cal_q[F_MON] != 8'h00)); // R2
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        timer_irq,
  output logic        alarm_irq
);
  localparam logic [7:0] TIME_BASE  = 8'h00;
  localparam logic [7:0] ALARM_BASE = 8'h20;
  localparam logic [7:0] CTRL_ADDR  = 8'h40;
  localparam logic [7:0] STAT_ADDR  = 8'h44;
  localparam logic [7:0] IEN_ADDR   = 8'h48;
  localparam int ST_BUSY = 0, ST_RUN = 1, ST_SEC = 2, ST_ALM = 6;
  localparam int IE_TMR = 2, IE_ALM = 3;

  logic              unlocked, wr_ok, busy, step;
  logic              run_q, run_d;
  logic              sec_ev_q, sec_ev_d, alm_q, alm_d, step_q;
  logic              ien_tmr_q, ien_tmr_d, ien_alm_q, ien_alm_d;
  logic [NFIELD-1:0] ld_en;
  cal_t              cal, alarm_cal;

  assign wr_ok = bus_wr && unlocked;

  rtc_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .unlocked(unlocked)
  );

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick_en(tick_en),
    .busy(busy), .step(step)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .step(step), .ld_en(ld_en),
    .ld_data(bus_wdata[7:0]), .cal_q(cal)
  );

  // per-field write decode and alarm registers
  for (genvar gi = 0; gi < NFIELD; gi++) begin : g_field
    logic [7:0] alm_fld_q, alm_fld_d;
    logic       alm_we;
    assign ld_en[gi] = wr_ok && (bus_addr == TIME_BASE + 8'(4*gi));
    assign alm_we    = wr_ok && (bus_addr == ALARM_BASE + 8'(4*gi));
    always_comb alm_fld_d = alm_we ? bus_wdata[7:0] : alm_fld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alm_fld_q <= 8'h00;
      else        alm_fld_q <= alm_fld_d;
    end
    assign alarm_cal[gi] = alm_fld_q;
  end

  logic ctrl_we, stat_we, ien_we;
  assign ctrl_we = wr_ok && (bus_addr == CTRL_ADDR);
  assign stat_we = wr_ok && (bus_addr == STAT_ADDR);
  assign ien_we  = wr_ok && (bus_addr == IEN_ADDR);

  always_comb begin
    run_d     = ctrl_we ? bus_wdata[0] : run_q;
    ien_tmr_d = ien_we ? bus_wdata[IE_TMR] : ien_tmr_q;
    ien_alm_d = ien_we ? bus_wdata[IE_ALM] : ien_alm_q;
    sec_ev_d  = step | (sec_ev_q & ~(stat_we & bus_wdata[ST_SEC]));
    alm_d     = (step_q && (cal == alarm_cal)) | (alm_q & ~(stat_we & bus_wdata[ST_ALM]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      ien_tmr_q <= 1'b0;
      ien_alm_q <= 1'b0;
      sec_ev_q  <= 1'b0;
      alm_q     <= 1'b0;
      step_q    <= 1'b0;
    end else begin
      run_q     <= run_d;
      ien_tmr_q <= ien_tmr_d;
      ien_alm_q <= ien_alm_d;
      sec_ev_q  <= sec_ev_d;
      alm_q     <= alm_d;
      step_q    <= step;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NFIELD; i++) begin
      if (bus_addr == TIME_BASE + 8'(4*i))  bus_rdata = cal[i];
      if (bus_addr == ALARM_BASE + 8'(4*i)) bus_rdata = alarm_cal[i];
    end
    if (bus_addr == CTRL_ADDR) bus_rdata = {7'b0, run_q};
    if (bus_addr == STAT_ADDR) begin
      bus_rdata[ST_BUSY] = busy;
      bus_rdata[ST_RUN]  = run_q;
      bus_rdata[ST_SEC]  = sec_ev_q;
      bus_rdata[ST_ALM]  = alm_q;
    end
    if (bus_addr == IEN_ADDR) begin
      bus_rdata[IE_TMR] = ien_tmr_q;
      bus_rdata[IE_ALM] = ien_alm_q;
    end
  end

  assign timer_irq = sec_ev_q & ien_tmr_q;
  assign alarm_irq = alm_q & ien_alm_q;

  AST_EVENT_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_ev_q) |-> $past(busy)); // R6
  AST_ALARM_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_q) |-> $past(step, 2)); // R8
  AST_LOCKED_TIME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(unlocked) && !$past(step)) |-> $stable(cal)); // R11
endmodule

// File: tb/sim_bcd_rtc.sv
`timescale 1ns/1ps
module sim_bcd_rtc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [7:0]  bus_rdata;
  logic        timer_irq, alarm_irq;

  localparam int TPS = 4;
  localparam logic [31:0] KA = 32'h83E70B13;
  localparam logic [31:0] KB = 32'h95A4F1E0;

  bcd_rtc #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timer_irq(timer_irq), .alarm_irq(alarm_irq)
  );

  always #10 clk = ~clk;

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  int  checks = 0, failures = 0;
  logic probe = 1'b0;
  bit  done = 1'b0;

  // monitor: pops one expectation per probe
  always @(negedge clk) begin
    if (probe) begin
      item_t it;
      logic [7:0] act;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty");
      end else begin
        it = sb.pop_front();
        case (it.kind)
          1:       act = {7'b0, timer_irq};
          2:       act = {7'b0, alarm_irq};
          default: act = bus_rdata;
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1 bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic expect_k(input int kind, input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    @(posedge clk); #1 bus_addr = a; sb.push_back(it); probe = 1'b1;
    @(negedge clk); #1 probe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    expect_k(0, a, e, tag);
  endtask

  task automatic tick(input int n);
    @(posedge clk); #1 tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] yr, mo, dy, hr, mn, sc);
    wr(8'h14, {24'h0, yr}); wr(8'h10, {24'h0, mo}); wr(8'h0C, {24'h0, dy});
    wr(8'h08, {24'h0, hr}); wr(8'h04, {24'h0, mn}); wr(8'h00, {24'h0, sc});
  endtask

  task automatic one_second;
    wr(8'h40, 32'h1); tick(TPS); wr(8'h40, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(8'h00, 8'h00, "R1 reset seconds");
    rd(8'h0C, 8'h01, "R1 reset day");
    rd(8'h10, 8'h01, "R1 reset month");
    rd(8'h44, 8'h00, "R7 reset status");
    expect_k(1, 8'h00, 8'h00, "R9 reset timer_irq");
    expect_k(2, 8'h00, 8'h00, "R9 reset alarm_irq");

    wr(8'h00, 32'h33);
    rd(8'h00, 8'h00, "R11 write while locked ignored");
    wr(8'h70, KB); wr(8'h6C, KA); wr(8'h00, 32'h33);
    rd(8'h00, 8'h00, "R11 reversed keys do not unlock");
    wr(8'h70, KB);
    wr(8'h00, 32'h58);
    rd(8'h00, 8'h58, "R10 write after unlock");

    wr(8'h40, 32'h09);
    rd(8'h40, 8'h01, "R12 control keeps only run bit");
    rd(8'h44, 8'h02, "R7 running bit");
    tick(TPS - 1);
    rd(8'h44, 8'h03, "R6 busy in last tick period");
    rd(8'h00, 8'h58, "R5 no step before last tick");
    tick(1);
    rd(8'h00, 8'h59, "R5 one second after TPS ticks");
    rd(8'h44, 8'h06, "R6 R7 busy drops, event set");
    expect_k(1, 8'h00, 8'h00, "R9 timer_irq masked");
    wr(8'h48, 32'h04);
    expect_k(1, 8'h00, 8'h01, "R9 timer_irq enabled");
    wr(8'h44, 32'h04);
    expect_k(1, 8'h00, 8'h00, "R7 event cleared by W1C");
    rd(8'h44, 8'h02, "R7 status after clear");
    tick(TPS);
    rd(8'h00, 8'h00, "R1 seconds wrap");
    rd(8'h04, 8'h01, "R1 minute carry");

    wr(8'h40, 32'h0);
    tick(2 * TPS);
    rd(8'h00, 8'h00, "R5 stopped clock holds");

    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    one_second();
    rd(8'h0C, 8'h29, "R3 leap Feb 28 -> 29");
    rd(8'h10, 8'h02, "R3 leap month stays Feb");
    rd(8'h08, 8'h00, "R1 hours wrap 23 -> 00");

    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    one_second();
    rd(8'h0C, 8'h01, "R3 common Feb 28 -> 01");
    rd(8'h10, 8'h03, "R3 common Feb -> Mar");

    set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
    one_second();
    rd(8'h0C, 8'h01, "R3 leap Feb 29 -> 01");

    set_time(8'h21, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    one_second();
    rd(8'h0C, 8'h01, "R2 April 30 -> 01");
    rd(8'h10, 8'h05, "R2 April -> May");

    set_time(8'h21, 8'h05, 8'h30, 8'h23, 8'h59, 8'h59);
    one_second();
    rd(8'h0C, 8'h31, "R2 May 30 -> 31");

    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    one_second();
    rd(8'h14, 8'h00, "R4 year 99 -> 00");
    rd(8'h10, 8'h01, "R4 month 12 -> 01");
    rd(8'h0C, 8'h01, "R4 day -> 01");

    wr(8'h48, 32'h08);
    set_time(8'h25, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30);
    wr(8'h34, 32'h26); wr(8'h30, 32'h06); wr(8'h2C, 32'h15);
    wr(8'h28, 32'h10); wr(8'h24, 32'h20); wr(8'h20, 32'h31);
    one_second();
    expect_k(2, 8'h00, 8'h00, "R8 year mismatch no alarm");
    wr(8'h34, 32'h25);
    rd(8'h34, 8'h25, "R12 alarm year register");
    wr(8'h00, 32'h30);
    one_second();
    expect_k(2, 8'h00, 8'h01, "R8 R9 exact match raises alarm_irq");
    rd(8'h44, 8'h44, "R7 alarm and event flags");
    wr(8'h44, 32'h40);
    expect_k(2, 8'h00, 8'h00, "R7 alarm cleared by W1C");

    wr(8'h6C, 32'h0);
    wr(8'h00, 32'h11);
    rd(8'h00, 8'h31, "R11 relock ignores writes");

    finish_run();
  end
endmodule